// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block sits in the transmit path ahead of a MAC. For every outgoing frame it first receives a short control transfer of 32-bit words on a control stream. It then receives the frame bytes on a separate byte-wide data stream. If the control words request it, the block sums a byte range of the frame as a 16-bit one's-complement value. The range runs from a chosen start offset to the final byte. The block adds a seed, folds the result, complements it and writes it into the frame at a chosen byte offset. The frame then leaves on an output stream, unchanged in length.

The checksum field can lie ahead of the bytes it covers. For that reason the whole frame is held in an internal byte buffer before anything is emitted. The sum itself is accumulated while the bytes arrive, so the only extra cost after the last input byte is a single finishing cycle. After that the buffered frame is replayed with the two checksum bytes substituted.

Top module: `csum_insert_top`

## Requirements
- R1: A control transfer is accepted only when it holds exactly CTRL_WORDS (default 5) beats, with TLAST on the last beat. Each word's value is taken with tdata[7:0] as its least significant byte. A transfer of any other length pulses `ctrl_len_err` for one cycle, in the cycle after its TLAST beat, and leaves the active settings unchanged.
- R2: When bit 0 of control word 0 is 0, the frame is emitted byte for byte unchanged.
- R3: Control word 1 bits [31:16] give the coverage start offset, and bits [15:0] give the insertion offset. Covered bytes are paired big-endian relative to the start offset: an even distance from the start is the high byte. An odd final byte is padded with a zero low byte.
- R4: Control word 2 bits [15:0] are added to the 32-bit sum. The sum is folded with end-around carry to 16 bits and complemented. The high byte of the result replaces the byte at the insertion offset, and the low byte replaces the byte that follows it.
- R5: The most recently accepted control transfer applies to every frame whose first byte arrives after it, until another control transfer is accepted. After reset, insertion is disabled.
- R6: The output frame has the same byte count and order as the input frame, with TLAST on its final byte only.
- R7: A frame longer than MAX_BYTES pulses `frame_err`. Only its first MAX_BYTES bytes are emitted, unmodified, with TLAST on the last of them.
- R8: With insertion enabled, a start offset larger than the frame length, or an insertion offset plus 2 larger than the frame length, pulses `frame_err`. The frame is then emitted unmodified.
- R9: `s_data_tready` is low from the frame's TLAST beat until the output TLAST beat is accepted, and it is never high while `m_tvalid` is high.
- R10: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R11: During and after reset, `m_tvalid`, `frame_err` and `ctrl_len_err` are low, and both input TREADY signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_ctrl_tdata | input | 32 | Control word |
| s_ctrl_tvalid | input | 1 | Control beat valid |
| s_ctrl_tlast | input | 1 | Last control word of a transfer |
| s_ctrl_tready | output | 1 | Control ready (always high) |
| s_data_tdata | input | 8 | Frame byte in |
| s_data_tvalid | input | 1 | Frame byte valid |
| s_data_tlast | input | 1 | Last byte of frame |
| s_data_tready | output | 1 | Frame intake ready |
| m_tdata | output | 8 | Frame byte out |
| m_tvalid | output | 1 | Output byte valid |
| m_tlast | output | 1 | Last output byte |
| m_tready | input | 1 | Downstream ready |
| ctrl_len_err | output | 1 | One-cycle pulse: bad control transfer length |
| frame_err | output | 1 | One-cycle pulse: oversize frame or offsets outside the frame |

## Verification
The bench builds the block with MAX_BYTES = 64 and the default of 5 control words. With a buffer that small, an oversize frame of 70 bytes is cheap to send, and every start and insertion offset of short frames can be swept. The sweep covers all start offsets from 0 up to one past the frame length, for frame lengths from 1 to 16 bytes. That reaches the odd-tail padding, the coverage of zero bytes and both kinds of offset error. The expected checksum is computed arithmetically in the bench. Each frame is replayed under a rotating pattern of downstream stalls.

// File: rtl/csum_pkg.sv
package csum_pkg;

  typedef struct packed {
    logic        en;
    logic [15:0] start;
    logic [15:0] ins;
    logic [15:0] seed;
  } csum_cfg_t;

  typedef enum logic [2:0] {
    ST_RECV,
    ST_FIN,
    ST_FETCH,
    ST_LOAD,
    ST_HOLD
  } eng_state_t;

  // Two end-around-carry steps fold any 32-bit value into 16 bits with no carry left.
  function automatic logic [15:0] fold_cpl(input logic [31:0] s);
    logic [16:0] a;
    logic [16:0] b;
    a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    b = {1'b0, a[15:0]} + {16'b0, a[16]};
    return ~b[15:0];
  endfunction

endpackage

// File: rtl/csum_ctrl_rx.sv
module csum_ctrl_rx
  import csum_pkg::*;
#(
  parameter int WORDS = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] tdata,
  input  logic        tvalid,
  input  logic        tlast,
  output logic        tready,
  output csum_cfg_t   cfg_o,
  output logic        err_o
);
  localparam int CW = $clog2(WORDS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WORDS - 1);
  localparam logic [CW-1:0] SAT_IDX  = CW'(WORDS);

  logic [CW-1:0] cnt;
  logic          st_en;
  logic [31:0]   st_w1;
  logic [15:0]   st_seed;

  assign tready = 1'b1;

  // tdata[7:0] is the least significant byte of the word, so no lane swap is needed here.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      st_en   <= 1'b0;
      st_w1   <= '0;
      st_seed <= '0;
      cfg_o   <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (tvalid) begin
        if (cnt == CW'(0)) st_en   <= tdata[0];
        if (cnt == CW'(1)) st_w1   <= tdata;
        if (cnt == CW'(2)) st_seed <= tdata[15:0];
        if (tlast) begin
          cnt <= '0;
          if (cnt == LAST_IDX) begin
            cfg_o.en    <= st_en;
            cfg_o.start <= st_w1[31:16];
            cfg_o.ins   <= st_w1[15:0];
            cfg_o.seed  <= st_seed;
          end else begin
            err_o <= 1'b1;
          end
        end else if (cnt != SAT_IDX) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/csum_frame_buf.sv
module csum_frame_buf #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rq
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end

endmodule

// File: rtl/csum_engine.sv
module csum_engine
  import csum_pkg::*;
#(
  parameter int MAX_BYTES = 2048,
  parameter int AW        = $clog2(MAX_BYTES),
  parameter int PW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  csum_cfg_t     cfg_i,
  input  logic [7:0]    s_tdata,
  input  logic          s_tvalid,
  input  logic          s_tlast,
  output logic          s_tready,
  output logic [7:0]    m_tdata,
  output logic          m_tvalid,
  output logic          m_tlast,
  input  logic          m_tready,
  output logic          buf_we,
  output logic [AW-1:0] buf_wa,
  output logic [7:0]    buf_wd,
  output logic [AW-1:0] buf_ra,
  input  logic [7:0]    buf_rq,
  output logic          err_o
);
  localparam logic [PW-1:0] FULL = PW'(MAX_BYTES);

  eng_state_t    state;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic          ovf;
  logic [31:0]   acc;
  csum_cfg_t     snap;
  csum_cfg_t     eff;
  logic          do_patch;
  logic [15:0]   csum;

  logic [15:0]   idx16;
  logic [15:0]   rd16;
  logic [16:0]   len17;
  logic          beat;
  logic          in_cov;
  logic [31:0]   addend;
  logic          bad_off;
  logic [PW-1:0] rd_next;
  logic [7:0]    out_byte;

  assign s_tready = (state == ST_RECV);
  assign beat     = s_tready && s_tvalid;

  // The first byte of a frame takes the live settings; later bytes use the snapshot.
  assign eff    = (wr_ptr == '0) ? cfg_i : snap;
  assign idx16  = {{(16-PW){1'b0}}, wr_ptr};
  assign rd16   = {{(16-PW){1'b0}}, rd_ptr};
  assign len17  = {1'b0, idx16};
  assign in_cov = (idx16 >= eff.start);
  assign addend = (idx16[0] == eff.start[0]) ? {16'b0, s_tdata, 8'b0} : {24'b0, s_tdata};

  assign bad_off = ({1'b0, snap.start} > len17) || (({1'b0, snap.ins} + 17'd2) > len17);

  assign buf_we = beat && (wr_ptr != FULL);
  assign buf_wa = wr_ptr[AW-1:0];
  assign buf_wd = s_tdata;

  assign rd_next = rd_ptr + 1'b1;
  assign buf_ra  = (state == ST_HOLD && m_tready) ? rd_next[AW-1:0] : rd_ptr[AW-1:0];

  always_comb begin
    out_byte = buf_rq;
    if (do_patch) begin
      if (rd16 == snap.ins)              out_byte = csum[15:8];
      else if (rd16 == snap.ins + 16'd1) out_byte = csum[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RECV;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      ovf      <= 1'b0;
      acc      <= '0;
      snap     <= '0;
      do_patch <= 1'b0;
      csum     <= '0;
      m_tdata  <= '0;
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      err_o <= 1'b0;
      unique case (state)
        ST_RECV: begin
          if (beat) begin
            if (wr_ptr == '0) snap <= cfg_i;
            if (wr_ptr == FULL) begin
              ovf <= 1'b1;
            end else begin
              wr_ptr <= wr_ptr + 1'b1;
              if (in_cov) acc <= acc + addend;
            end
            if (s_tlast) state <= ST_FIN;
          end
        end
        ST_FIN: begin
          csum     <= fold_cpl(acc + {16'b0, snap.seed});
          do_patch <= snap.en && !ovf && !bad_off;
          err_o    <= ovf || (snap.en && bad_off);
          rd_ptr   <= '0;
          state    <= ST_FETCH;
        end
        ST_FETCH: begin
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          m_tdata  <= out_byte;
          m_tvalid <= 1'b1;
          m_tlast  <= (rd_next == wr_ptr);
          state    <= ST_HOLD;
        end
        ST_HOLD: begin
          if (m_tready) begin
            m_tvalid <= 1'b0;
            if (m_tlast) begin
              m_tlast <= 1'b0;
              wr_ptr  <= '0;
              ovf     <= 1'b0;
              acc     <= '0;
              state   <= ST_RECV;
            end else begin
              rd_ptr <= rd_next;
              state  <= ST_LOAD;
            end
          end
        end
        default: state <= ST_RECV;
      endcase
    end
  end

endmodule

// File: rtl/csum_insert_top.sv
module csum_insert_top
  import csum_pkg::*;
#(
  parameter int MAX_BYTES  = 2048,
  parameter int CTRL_WORDS = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] s_ctrl_tdata,
  input  logic        s_ctrl_tvalid,
  input  logic        s_ctrl_tlast,
  output logic        s_ctrl_tready,
  input  logic [7:0]  s_data_tdata,
  input  logic        s_data_tvalid,
  input  logic        s_data_tlast,
  output logic        s_data_tready,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  output logic        m_tlast,
  input  logic        m_tready,
  output logic        ctrl_len_err,
  output logic        frame_err
);
  localparam int AW = $clog2(MAX_BYTES);
  localparam int PW = AW + 1;

  csum_cfg_t     cfg;
  logic          buf_we;
  logic [AW-1:0] buf_wa;
  logic [7:0]    buf_wd;
  logic [AW-1:0] buf_ra;
  logic [7:0]    buf_rq;

  csum_ctrl_rx #(.WORDS(CTRL_WORDS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tdata  (s_ctrl_tdata),
    .tvalid (s_ctrl_tvalid),
    .tlast  (s_ctrl_tlast),
    .tready (s_ctrl_tready),
    .cfg_o  (cfg),
    .err_o  (ctrl_len_err)
  );

  csum_frame_buf #(.DEPTH(MAX_BYTES), .AW(AW)) u_buf (
    .clk (clk),
    .we  (buf_we),
    .wa  (buf_wa),
    .wd  (buf_wd),
    .ra  (buf_ra),
    .rq  (buf_rq)
  );

  csum_engine #(.MAX_BYTES(MAX_BYTES), .AW(AW), .PW(PW)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .cfg_i    (cfg),
    .s_tdata  (s_data_tdata),
    .s_tvalid (s_data_tvalid),
    .s_tlast  (s_data_tlast),
    .s_tready (s_data_tready),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tlast  (m_tlast),
    .m_tready (m_tready),
    .buf_we   (buf_we),
    .buf_wa   (buf_wa),
    .buf_wd   (buf_wd),
    .buf_ra   (buf_ra),
    .buf_rq   (buf_rq),
    .err_o    (frame_err)
  );

endmodule

// File: rtl/csum_insert_sva.sv
module csum_insert_sva (
  input logic       clk,
  input logic       rst,
  input logic       s_ctrl_tvalid,
  input logic       s_ctrl_tlast,
  input logic       s_data_tvalid,
  input logic       s_data_tlast,
  input logic       s_data_tready,
  input logic [7:0] m_tdata,
  input logic       m_tvalid,
  input logic       m_tlast,
  input logic       m_tready,
  input logic       ctrl_len_err
);
  a_r10_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  a_r9_no_intake_while_emit: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> !s_data_tready);

  a_r9_close_after_last: assert property (@(posedge clk) disable iff (rst)
    (s_data_tvalid && s_data_tready && s_data_tlast) |=> !s_data_tready);

  a_r6_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    m_tlast |-> m_tvalid);

  a_r1_err_follows_last: assert property (@(posedge clk) disable iff (rst)
    ctrl_len_err |-> $past(s_ctrl_tvalid && s_ctrl_tlast));

  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!m_tvalid && !ctrl_len_err));

endmodule

bind csum_insert_top csum_insert_sva u_sva (
  .clk           (clk),
  .rst           (rst),
  .s_ctrl_tvalid (s_ctrl_tvalid),
  .s_ctrl_tlast  (s_ctrl_tlast),
  .s_data_tvalid (s_data_tvalid),
  .s_data_tlast  (s_data_tlast),
  .s_data_tready (s_data_tready),
  .m_tdata       (m_tdata),
  .m_tvalid      (m_tvalid),
  .m_tlast       (m_tlast),
  .m_tready      (m_tready),
  .ctrl_len_err  (ctrl_len_err)
);

// File: tb/csum_insert_top_tb.sv
module csum_insert_top_tb;
  localparam int MAXB = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] s_ctrl_tdata = '0;
  logic        s_ctrl_tvalid = 1'b0;
  logic        s_ctrl_tlast = 1'b0;
  logic        s_ctrl_tready;
  logic [7:0]  s_data_tdata = '0;
  logic        s_data_tvalid = 1'b0;
  logic        s_data_tlast = 1'b0;
  logic        s_data_tready;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tlast;
  logic        m_tready = 1'b0;
  logic        ctrl_len_err;
  logic        frame_err;

  int checks = 0;
  int errors = 0;
  int n_ctrl_err = 0;
  int n_frame_err = 0;
  int stall_viol = 0;
  int intake_viol = 0;
  int last_viol = 0;
  bit done = 0;

  logic [7:0] tx [0:127];
  logic [7:0] rx [0:127];
  logic [7:0] ex [0:127];

  always #2 clk = ~clk;

  csum_insert_top #(.MAX_BYTES(MAXB), .CTRL_WORDS(5)) u_dut (
    .clk(clk), .rst(rst),
    .s_ctrl_tdata(s_ctrl_tdata), .s_ctrl_tvalid(s_ctrl_tvalid),
    .s_ctrl_tlast(s_ctrl_tlast), .s_ctrl_tready(s_ctrl_tready),
    .s_data_tdata(s_data_tdata), .s_data_tvalid(s_data_tvalid),
    .s_data_tlast(s_data_tlast), .s_data_tready(s_data_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
    .ctrl_len_err(ctrl_len_err), .frame_err(frame_err)
  );

  always @(posedge clk) begin
    if (!rst && ctrl_len_err) n_ctrl_err++;
    if (!rst && frame_err) n_frame_err++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_csum(input int start, input int len, input int seed);
    int s = 0;
    for (int i = start; i < len; i++)
      s += ((i - start) % 2 == 0) ? (int'(tx[i]) << 8) : int'(tx[i]);
    s += seed;
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return (~s) & 32'hFFFF;
  endfunction

  task automatic send_ctrl(input int n, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_ctrl_tvalid = 1'b1;
      s_ctrl_tdata  = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : 32'hA5A5_0000 + i;
      s_ctrl_tlast  = (i == n - 1);
    end
    @(negedge clk);
    s_ctrl_tvalid = 1'b0;
    s_ctrl_tlast  = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_data_tvalid = 1'b1;
      s_data_tdata  = tx[i];
      s_data_tlast  = (i == len - 1);
      while (!s_data_tready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_data_tvalid = 1'b0;
    s_data_tlast  = 1'b0;
  endtask

  // Collects one output frame; the ready pattern is set at negedges.
  task automatic recv_frame(input int mode, output int got);
    bit fin = 0;
    bit prev_stall = 0;
    logic [7:0] prev_d = '0;
    logic prev_l = 1'b0;
    got = 0;
    for (int k = 0; k < 2000 && !fin; k++) begin
      @(negedge clk);
      if (prev_stall && (!m_tvalid || m_tdata != prev_d || m_tlast != prev_l)) stall_viol++;
      if (m_tvalid && s_data_tready) intake_viol++;
      case (mode)
        0: m_tready = 1'b1;
        1: m_tready = (k % 3) != 0;
        default: m_tready = ((k / 2) % 2) == 1;
      endcase
      prev_stall = m_tvalid && !m_tready;
      prev_d = m_tdata;
      prev_l = m_tlast;
      if (m_tvalid && m_tready) begin
        rx[got] = m_tdata;
        if (m_tlast) fin = 1;
        got++;
      end
    end
    @(negedge clk);
    m_tready = 1'b0;
    if (!fin) last_viol++;
  endtask

  task automatic run_case(input bit en, input int start, input int ins, input int seed,
                          input int len, input int mode, input bit send_cfg, input string req);
    int got;
    int exp_len;
    int bad_idx;
    bit exp_err;
    bit patch;
    int cs;
    int ce0;
    for (int i = 0; i < len; i++) tx[i] = 8'((i * 37 + len * 11 + seed + start * 5) & 8'hFF);
    if (send_cfg) send_ctrl(5, {31'b0, en}, {16'(start), 16'(ins)}, {16'h0, 16'(seed)});
    exp_len = (len > MAXB) ? MAXB : len;
    exp_err = (len > MAXB) || (en && (start > len || ins + 2 > len));
    patch   = en && !exp_err;
    for (int i = 0; i < exp_len; i++) ex[i] = tx[i];
    if (patch) begin
      cs = model_csum(start, len, seed);
      ex[ins]     = 8'(cs >> 8);
      ex[ins + 1] = 8'(cs);
    end
    ce0 = n_frame_err;
    send_frame(len);
    recv_frame(mode, got);
    repeat (2) @(negedge clk);
    bad_idx = -1;
    for (int i = 0; i < exp_len && i < got; i++)
      if (rx[i] !== ex[i] && bad_idx < 0) bad_idx = i;
    check(got == exp_len, req, $sformatf("length (start %0d ins %0d len %0d)", start, ins, len), got, exp_len);
    check(bad_idx < 0, req, $sformatf("byte %0d value (start %0d ins %0d len %0d)", bad_idx, start, ins, len),
          (bad_idx < 0) ? 0 : int'(rx[bad_idx]), (bad_idx < 0) ? 0 : int'(ex[bad_idx]));
    check((n_frame_err - ce0) == int'(exp_err), exp_err ? "R8" : req, "frame_err pulses", n_frame_err - ce0, int'(exp_err));
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ce;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check(m_tvalid == 1'b0, "R11", "m_tvalid in reset", m_tvalid, 0);
    check(s_data_tready == 1'b1 && s_ctrl_tready == 1'b1, "R11", "readies in reset",
          int'(s_data_tready & s_ctrl_tready), 1);
    rst = 1'b0;
    @(negedge clk);
    check(frame_err == 1'b0 && ctrl_len_err == 1'b0, "R11", "error flags after reset", int'(frame_err | ctrl_len_err), 0);

    // R11/R5: no control yet means insertion is off
    run_case(1'b0, 0, 0, 0, 9, 0, 1'b0, "R11");

    // R2: disabled insertion passes the frame through
    run_case(1'b0, 2, 4, 16'h1234, 12, 1, 1'b1, "R2");
    run_case(1'b0, 0, 0, 16'hFFFF, 3, 2, 1'b1, "R2");

    // R3/R4: sweep start offsets of short frames (R8 where offsets fall outside)
    for (int len = 1; len <= 16; len++)
      for (int st = 0; st <= len + 1; st++)
        run_case(1'b1, st, (st * 3 + len) % (len + 1), (st * 4099 + len * 257) & 16'hFFFF,
                 len, (st + len) % 3, 1'b1, (len % 2) ? "R3" : "R4");

    // R4: checksum field ahead of and behind coverage, large seed causing double fold
    run_case(1'b1, 20, 2, 16'hFFFF, 40, 1, 1'b1, "R4");
    run_case(1'b1, 0, 38, 16'hFFFE, 40, 2, 1'b1, "R4");

    // R5: settings persist for a following frame with no new control transfer
    run_case(1'b1, 4, 0, 16'h0101, 20, 0, 1'b1, "R5");
    run_case(1'b1, 4, 0, 16'h0101, 18, 1, 1'b0, "R5");

    // R1: short and long control transfers are rejected and leave the settings alone
    ce = n_ctrl_err;
    send_ctrl(4, 32'h0, 32'h0003_0005, 32'h0);
    repeat (2) @(negedge clk);
    check((n_ctrl_err - ce) == 1, "R1", "error pulses on 4-word transfer", n_ctrl_err - ce, 1);
    ce = n_ctrl_err;
    send_ctrl(6, 32'h0, 32'h0003_0005, 32'h0);
    repeat (2) @(negedge clk);
    check((n_ctrl_err - ce) == 1, "R1", "error pulses on 6-word transfer", n_ctrl_err - ce, 1);
    run_case(1'b1, 4, 0, 16'h0101, 22, 2, 1'b0, "R1");
    ce = n_ctrl_err;
    run_case(1'b1, 1, 6, 16'h00FF, 15, 0, 1'b1, "R1");
    check(n_ctrl_err == ce, "R1", "no error on 5-word transfer", n_ctrl_err - ce, 0);

    // R7: oversize frame, truncated and unmodified
    run_case(1'b1, 0, 0, 16'h0, 70, 1, 1'b1, "R7");
    // R6: a full-buffer frame still gets its checksum
    run_case(1'b1, 10, 60, 16'h5A5A, 64, 2, 1'b1, "R6");

    check(stall_viol == 0, "R10", "output changed while stalled", stall_viol, 0);
    check(intake_viol == 0, "R9", "intake ready while emitting", intake_viol, 0);
    check(last_viol == 0, "R6", "frames missing TLAST", last_viol, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule